// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller behind a simple APB-style register bus with 32-bit data. It holds up to four pin ports. Each port has an output value register and a direction register that software writes and reads back, plus a read-only view of its pins. Every pin input passes through a two-flop synchroniser before any logic or read-back sees it.

The first port (port A) also carries a per-pin interrupt unit. Each pin can be set to level or edge sensing, and a separate polarity bit picks the active sense. Edge events are held until software clears them through an end-of-interrupt write. Level requests track the pin directly. Enable and mask registers qualify the status word. A single registered interrupt line is raised whenever any status bit is set. There is no hardware both-edge mode. Software emulates it by flipping the polarity bit after each event, and the new polarity applies from the next detection without creating an event of its own.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pin_out`, `pin_oe` and `irq` are zero, and the status word is zero.
- R2: Reading byte offset 0x50 + 4*p returns the pins of port p through a two-flop synchroniser. A pin change applied before a clock edge is still invisible after one edge and is visible after the second edge.
- R3: The output value register of port p sits at byte offset 0x0C*p and its direction register at 0x04 + 0x0C*p. Both are written when `psel`, `penable` and `pwrite` are all high, and both read back the written value. A write to one port leaves the other ports unchanged.
- R4: `pin_out` carries each port's output value register, and `pin_oe` carries its direction register (1 = drive). Both are placed port-by-port with port p at bits [p*PORT_W +: PORT_W], and each changes on the clock edge that completes the write.
- R5: A 1 in the type register (0x38) makes a port A pin edge-sensitive. A polarity bit (0x3C) of 1 selects rising edges and 0 selects falling edges. A detected edge sets the pin's pending bit only while its enable bit (0x30) is 1, and edges of the opposite sense set nothing.
- R6: An edge pending bit stays set until a 1 is written to that bit of the end-of-interrupt register (0x4C). Writing 0 to a bit leaves it set. The end-of-interrupt register reads as zero.
- R7: With its type bit at 0, a pin's pending bit equals its synchronised input when polarity is 1, and the inverted input when polarity is 0. An end-of-interrupt write does not change it.
- R8: The status register (0x40) reads pending AND enable AND NOT mask (0x34). A mask bit of 1 hides the pin from status and from `irq`.
- R9: `irq` is the OR of the status bits, delayed by one register. A level pin that goes active shows `irq` low after two clock edges and high after the third.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to the pin-view registers or to unmapped offsets change no register.
- R11: Rewriting a polarity bit creates no event by itself. The new sense applies from the next detection, so an edge-mode pin can be made to trigger on both edges by flipping its polarity after each event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase; a write takes effect when psel, penable and pwrite are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational, zero when no read is selected |
| pin_in | input | NUM_PORTS*PORT_W | Pin inputs, port p at [p*PORT_W +: PORT_W] |
| pin_out | output | NUM_PORTS*PORT_W | Output values for the pins |
| pin_oe | output | NUM_PORTS*PORT_W | Output enables (1 = drive the pin) |
| irq | output | 1 | Combined registered interrupt request |

## Verification
Every cycle, the assertions check four things. The synchroniser output must equal the pin value from two edges earlier. An unacknowledged edge pending bit must never drop. A pending bit may only rise while its pin is enabled. `irq` may only be high after a cycle with some pin enabled. They also check that a direction write reaches `pin_oe` on the next edge, and that a read of an unmapped offset returns zero. Other behaviour needs the bench's scenarios. These cover the exact cycle at which inputs and `irq` appear, rising versus falling selection, masking, level tracking that ignores acknowledgement, and both-edge emulation through polarity flips, all judged against values the bench works out itself.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, register selector type and address decoder for the
// GPIO bank controller. Assumes byte addressing on a 7-bit offset.
package gpio_bank_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned MAX_PORTS = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA_A   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_A    = 7'h04;
    localparam logic [ADDR_W-1:0] PORT_STRIDE  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 7'h30;
    localparam logic [ADDR_W-1:0] OFS_IRQ_MASK = 7'h34;
    localparam logic [ADDR_W-1:0] OFS_IRQ_TYPE = 7'h38;
    localparam logic [ADDR_W-1:0] OFS_IRQ_POL  = 7'h3C;
    localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 7'h40;
    localparam logic [ADDR_W-1:0] OFS_IRQ_ACK  = 7'h4C;
    localparam logic [ADDR_W-1:0] OFS_PIN_A    = 7'h50;
    localparam logic [ADDR_W-1:0] PIN_STRIDE   = 7'h04;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_PIN,
        SEL_EN, SEL_MASK, SEL_TYPE, SEL_POL, SEL_STAT, SEL_ACK
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] port;
    } reg_hit_t;

    // Map a byte offset to a register selector; ports at or above nports stay unmapped.
    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nports);
        reg_hit_t h;
        h.sel  = SEL_NONE;
        h.port = 2'd0;
        for (int unsigned p = 0; p < MAX_PORTS; p++) begin
            if (p < nports) begin
                if (a == OFS_DATA_A + 7'(p) * PORT_STRIDE) begin
                    h.sel = SEL_DATA; h.port = 2'(p);
                end
                if (a == OFS_DIR_A + 7'(p) * PORT_STRIDE) begin
                    h.sel = SEL_DIR; h.port = 2'(p);
                end
                if (a == OFS_PIN_A + 7'(p) * PIN_STRIDE) begin
                    h.sel = SEL_PIN; h.port = 2'(p);
                end
            end
        end
        if (a == OFS_IRQ_EN)   h.sel = SEL_EN;
        if (a == OFS_IRQ_MASK) h.sel = SEL_MASK;
        if (a == OFS_IRQ_TYPE) h.sel = SEL_TYPE;
        if (a == OFS_IRQ_POL)  h.sel = SEL_POL;
        if (a == OFS_IRQ_STAT) h.sel = SEL_STAT;
        if (a == OFS_IRQ_ACK)  h.sel = SEL_ACK;
        return h;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is sampled independently (no multi-bit coherence).
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture the raw pins, then re-register them to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= din;
            stable_q <= meta_q;
        end
    end

    assign dout = stable_q;

    // Count edges since reset so the two-deep history check starts valid.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    a_r2_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
// Output value and direction registers of one pin port.
// Assumes the caller has already decoded the write strobes.
module gpio_port_regs #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);
    // Hold the value the port drives.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= wdata;
    end

    // Hold which pins are driven (1) or released (0).
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

endmodule

// File: rtl/gpio_irq_unit.sv
// Per-pin interrupt logic for port A: configuration registers, edge and
// level detection, sticky edge pending bits and a registered combined request.
// Assumes pin_sync is already synchronised to clk.
module gpio_irq_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_mask,
    input  logic             wr_type,
    input  logic             wr_pol,
    input  logic             wr_ack,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] type_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] status,
    output logic             irq
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] edge_pend_q;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] ack_clr;
    logic [WIDTH-1:0] level_pend;
    logic             irq_q;

    // Software-written configuration: enable, mask, sense type, polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_en)   en_q   <= wdata;
            if (wr_mask) mask_q <= wdata;
            if (wr_type) type_q <= wdata;
            if (wr_pol)  pol_q  <= wdata;
        end
    end

    // Keep last cycle's pin levels so edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    // Edge in the sense picked by polarity, level request and acknowledge bits.
    always_comb begin
        edge_hit   = (pol_q & pin_sync & ~prev_q) | (~pol_q & ~pin_sync & prev_q);
        ack_clr    = wr_ack ? wdata : '0;
        level_pend = ~type_q & ~(pin_sync ^ pol_q);
    end

    // Sticky edge pending: set by an enabled edge, cleared by acknowledge; new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_pend_q <= '0;
        else        edge_pend_q <= type_q & ((edge_pend_q & ~ack_clr) | (edge_hit & en_q));
    end

    // Qualified status word seen by software.
    assign status = (edge_pend_q | level_pend) & en_q & ~mask_q;

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status;
    end

    assign irq = irq_q;

    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_pend_q & ~ack_clr) & type_q & ~edge_pend_q) == '0));

    a_r5_latch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_pend_q & ~$past(edge_pend_q) & ~$past(en_q)) == '0));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_q != '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// GPIO bank controller: bus decode, per-port output/direction registers,
// synchronised pin read-back and a port A interrupt unit.
// Assumes PORT_W <= 32 and NUM_PORTS between 1 and 4; reads are combinational.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [BUS_W-1:0]              pwdata,
    output logic [BUS_W-1:0]              prdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
    output logic                          irq
);
    localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

    logic             wr_stb;
    reg_hit_t         hit;
    logic [PORT_W-1:0] wval;
    logic [PIN_W-1:0]  pin_sync;
    logic [PORT_W-1:0] data_q   [NUM_PORTS];
    logic [PORT_W-1:0] dir_q    [NUM_PORTS];
    logic [PORT_W-1:0] pin_view [NUM_PORTS];
    logic [PORT_W-1:0] en_q, mask_q, type_q, pol_q, status;
    logic [PORT_W-1:0] rd_val;

    // Decode the access once for writes and reads.
    assign wr_stb = psel & penable & pwrite;
    assign hit    = decode_addr(paddr, NUM_PORTS);
    assign wval   = pwdata[PORT_W-1:0];

    gpio_sync #(.WIDTH(PIN_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port_regs #(.WIDTH(PORT_W)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_data(wr_stb && hit.sel == SEL_DATA && hit.port == 2'(p)),
            .wr_dir (wr_stb && hit.sel == SEL_DIR  && hit.port == 2'(p)),
            .wdata  (wval),
            .data_q (data_q[p]),
            .dir_q  (dir_q[p])
        );
        assign pin_out[p*PORT_W +: PORT_W] = data_q[p];
        assign pin_oe[p*PORT_W +: PORT_W]  = dir_q[p];
        assign pin_view[p]                 = pin_sync[p*PORT_W +: PORT_W];
    end

    gpio_irq_unit #(.WIDTH(PORT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb && hit.sel == SEL_EN),
        .wr_mask (wr_stb && hit.sel == SEL_MASK),
        .wr_type (wr_stb && hit.sel == SEL_TYPE),
        .wr_pol  (wr_stb && hit.sel == SEL_POL),
        .wr_ack  (wr_stb && hit.sel == SEL_ACK),
        .wdata   (wval),
        .pin_sync(pin_view[0]),
        .en_q    (en_q),
        .mask_q  (mask_q),
        .type_q  (type_q),
        .pol_q   (pol_q),
        .status  (status),
        .irq     (irq)
    );

    // Read-back multiplexer; acknowledge and unmapped offsets read zero.
    always_comb begin
        unique case (hit.sel)
            SEL_DATA: rd_val = data_q[hit.port];
            SEL_DIR:  rd_val = dir_q[hit.port];
            SEL_PIN:  rd_val = pin_view[hit.port];
            SEL_EN:   rd_val = en_q;
            SEL_MASK: rd_val = mask_q;
            SEL_TYPE: rd_val = type_q;
            SEL_POL:  rd_val = pol_q;
            SEL_STAT: rd_val = status;
            default:  rd_val = '0;
        endcase
    end

    assign prdata = (psel && !pwrite) ? BUS_W'(rd_val) : '0;

    a_r4_dir_write_reaches_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && paddr == OFS_DIR_A) |=> (pin_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));

    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && hit.sel == SEL_NONE) |-> (prdata == '0));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
// Directed bench for gpio_bank_ctrl: one task per scenario, each checking itself.
module test_gpio_bank_ctrl;
    localparam int NP = 4;
    localparam int PW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [6:0]      paddr = '0;
    logic [31:0]     pwdata = '0;
    logic [31:0]     prdata;
    logic [NP*PW-1:0] pin_in = '0;
    logic [NP*PW-1:0] pin_out, pin_oe;
    logic            irq;

    int n_checks = 0;
    int n_fail   = 0;

    gpio_bank_ctrl #(.NUM_PORTS(NP), .PORT_W(PW)) i_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", pin_oe[31:0] | pin_oe[127:96], 32'h0);
        check("R1 pin_out", pin_out[63:32], 32'h0);
        bus_read(7'h00, v); check("R1 data A", v, 32'h0);
        bus_read(7'h04, v); check("R1 dir A", v, 32'h0);
        bus_read(7'h30, v); check("R1 enable", v, 32'h0);
        bus_read(7'h3C, v); check("R1 polarity", v, 32'h0);
        bus_read(7'h40, v); check("R1 status", v, 32'h0);
    endtask

    task automatic t_outputs();
        logic [31:0] v;
        bus_write(7'h0C, 32'hA5A5_0F0F);
        bus_write(7'h10, 32'hFFFF_0000);
        bus_write(7'h24, 32'h1357_9BDF);
        bus_write(7'h28, 32'h0000_FFFF);
        bus_read(7'h0C, v); check("R3 data B", v, 32'hA5A5_0F0F);
        bus_read(7'h10, v); check("R3 dir B", v, 32'hFFFF_0000);
        bus_read(7'h24, v); check("R3 data D", v, 32'h1357_9BDF);
        bus_read(7'h00, v); check("R3 data A untouched", v, 32'h0);
        bus_read(7'h1C, v); check("R3 dir C untouched", v, 32'h0);
        check("R4 pin_out B", pin_out[63:32], 32'hA5A5_0F0F);
        check("R4 pin_oe B", pin_oe[63:32], 32'hFFFF_0000);
        check("R4 pin_oe D", pin_oe[127:96], 32'h0000_FFFF);
        check("R4 pin_oe A", pin_oe[31:0], 32'h0);
    endtask

    task automatic t_inputs();
        logic [31:0] v;
        @(negedge clk);
        pin_in[95:64] = 32'h1234_5678;
        bus_read(7'h58, v); check("R2 one edge still old", v, 32'h0);
        bus_read(7'h58, v); check("R2 two edges visible", v, 32'h1234_5678);
        bus_read(7'h54, v); check("R2 port B pins", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        bus_write(7'h38, 32'h3);
        bus_write(7'h3C, 32'h1);
        bus_write(7'h34, 32'h0);
        bus_write(7'h30, 32'h3);
        idle(4);
        bus_read(7'h40, v); check("R5 no event at setup", v, 32'h0);
        pin_in[0] = 1'b1; idle(4);
        bus_read(7'h40, v); check("R5 rising edge latched", v, 32'h1);
        check("R9 irq raised", {31'b0, irq}, 32'h1);
        pin_in[0] = 1'b0; idle(4);
        bus_read(7'h40, v); check("R6 sticky after pin drop", v, 32'h1);
        bus_write(7'h4C, 32'h2);
        bus_read(7'h40, v); check("R6 other-bit ack keeps it", v, 32'h1);
        bus_write(7'h4C, 32'h1);
        bus_read(7'h40, v); check("R6 ack clears", v, 32'h0);
        idle(2);
        check("R9 irq dropped", {31'b0, irq}, 32'h0);
        bus_read(7'h4C, v); check("R6 ack reads zero", v, 32'h0);
        pin_in[1] = 1'b1; idle(4);
        bus_read(7'h40, v); check("R5 falling ignores rise", v, 32'h0);
        pin_in[1] = 1'b0; idle(4);
        bus_read(7'h40, v); check("R5 falling edge latched", v, 32'h2);
        bus_write(7'h4C, 32'h2);
        bus_write(7'h30, 32'h2);
        pin_in[0] = 1'b1; idle(4);
        pin_in[0] = 1'b0; idle(4);
        bus_write(7'h30, 32'h3);
        bus_read(7'h40, v); check("R5 disabled pin not latched", v, 32'h0);
    endtask

    task automatic t_both_edges();
        logic [31:0] v;
        pin_in[0] = 1'b1; idle(4);
        bus_read(7'h40, v); check("R11 rise caught", v, 32'h1);
        bus_write(7'h4C, 32'h1);
        bus_write(7'h3C, 32'h0);
        idle(3);
        bus_read(7'h40, v); check("R11 flip makes no event", v, 32'h0);
        pin_in[0] = 1'b0; idle(4);
        bus_read(7'h40, v); check("R11 fall caught after flip", v, 32'h1);
        bus_write(7'h4C, 32'h1);
        bus_read(7'h40, v); check("R11 cleared", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        bus_write(7'h3C, 32'h10);
        bus_write(7'h30, 32'h10);
        idle(3);
        check("R9 irq idle before level", {31'b0, irq}, 32'h0);
        @(negedge clk);
        pin_in[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 irq low after two edges", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq high after three edges", {31'b0, irq}, 32'h1);
        bus_read(7'h40, v); check("R7 active-high level", v, 32'h10);
        bus_write(7'h4C, 32'h10);
        bus_read(7'h40, v); check("R7 ack ignored", v, 32'h10);
        pin_in[4] = 1'b0; idle(4);
        bus_read(7'h40, v); check("R7 level follows pin", v, 32'h0);
        bus_write(7'h3C, 32'h0);
        bus_read(7'h40, v); check("R7 active-low level", v, 32'h10);
        idle(2);
        check("R9 irq from active-low", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(7'h34, 32'h10);
        bus_read(7'h40, v); check("R8 masked status", v, 32'h0);
        idle(2);
        check("R8 masked irq", {31'b0, irq}, 32'h0);
        bus_read(7'h34, v); check("R8 mask readback", v, 32'h10);
        bus_write(7'h34, 32'h0);
        bus_read(7'h40, v); check("R8 unmasked status", v, 32'h10);
        bus_write(7'h30, 32'h0);
        bus_read(7'h40, v); check("R8 disabled status", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_read(7'h08, v); check("R10 read 0x08", v, 32'h0);
        bus_read(7'h44, v); check("R10 read 0x44", v, 32'h0);
        bus_read(7'h60, v); check("R10 read 0x60", v, 32'h0);
        bus_read(7'h02, v); check("R10 misaligned read", v, 32'h0);
        pin_in[31:16] = 16'hBEEF; idle(3);
        bus_write(7'h50, 32'h0000_1234);
        bus_read(7'h50, v); check("R10 pin view not writable", v, 32'hBEEF_0000);
        bus_write(7'h08, 32'hFFFF_FFFF);
        bus_write(7'h7C, 32'hFFFF_FFFF);
        bus_read(7'h00, v); check("R10 data A unchanged", v, 32'h0);
        bus_read(7'h04, v); check("R10 dir A unchanged", v, 32'h0);
        bus_read(7'h0C, v); check("R10 data B unchanged", v, 32'hA5A5_0F0F);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_outputs();
        t_inputs();
        t_edge();
        t_both_edges();
        t_level();
        t_mask();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule